// File: doc/BRIEF.md
# Quarter-Tile Signed 16-bit Outer-Product Subtractor

This block updates a square tile of 32-bit signed accumulators by subtracting two-term dot products formed from packed signed 16-bit lanes. The tile is split into four quadrants, and one quadrant is processed per clock. For the quadrant with row half `rh` and column half `ch`, the first operand is taken from `a_hi` only when `pair_a` is set and `ch` is 1. Otherwise it comes from `a_lo`. The second operand is taken from `b_hi` only when `pair_b` is set and `rh` is 1. Otherwise it comes from `b_lo`.

A pulse on `start` while the block is idle captures `tile_in` as a snapshot. The four quadrants are then computed from that snapshot in order 0, 1, 2, 3, where quadrant `q` has row half `q/2` and column half `q mod 2`. The finished tile appears on `tile_out` in the same cycle that `done` pulses. The vector width `VL` is a parameter, with a default of 128. It gives `DIM = VL/64` and a tile of `2·DIM × 2·DIM` elements. The operand inputs must remain unchanged from `start` until `done`.

Top module: `qtile_dotsub`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `tile_out` is all zeros.
- R2: When `start` is high at a rising edge while the block is idle, `busy` goes high after that edge. `done` is high for exactly one cycle, after the fourth rising edge that follows. `busy` is low again in that same cycle.
- R3: Tile element (r,c) lives at bits [32·idx+31 : 32·idx], where idx = r·2·DIM + c. Lane i of a vector lives at bits [16·i+15 : 16·i]. The new value of element (r,c) is old − (A[2r]·B[2c] + A[2r+1]·B[2c+1]), with all lanes treated as signed and r, c counted over the whole tile.
- R4: With `pair_a`=0, every element uses `a_lo`. With `pair_a`=1, columns c ≥ DIM use `a_hi` and columns c < DIM use `a_lo`.
- R5: With `pair_b`=0, every element uses `b_lo`. With `pair_b`=1, rows r ≥ DIM use `b_hi` and rows r < DIM use `b_lo`.
- R6: The subtraction wraps modulo 2^32, with no saturation. For example, 0x80000000 − 2 gives 0x7FFFFFFE.
- R7: The extreme input −32768 · −32768 is treated as the positive value 2^30. With all lanes at 0x8000 and a zero tile, every element becomes 0x80000000.
- R8: `tile_out` changes only in the cycle in which `done` is high, and holds its value at all other times.
- R9: A `start` pulse while `busy` is high is ignored. It neither changes the result nor moves the `done` cycle, even if `tile_in` differs at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an update when idle |
| pair_a | input | 1 | Use two first-operand vectors |
| pair_b | input | 1 | Use two second-operand vectors |
| a_lo | input | VL | First operand, vector 0 |
| a_hi | input | VL | First operand, vector 1 |
| b_lo | input | VL | Second operand, vector 0 |
| b_hi | input | VL | Second operand, vector 1 |
| tile_in | input | 4·DIM²·32 | Accumulator tile before the update |
| busy | output | 1 | Quadrants being computed |
| done | output | 1 | One-cycle completion pulse |
| tile_out | output | 4·DIM²·32 | Updated tile, held between updates |

## Verification
The bench drives distinct `a_hi`, `a_lo`, `b_hi` and `b_lo` vectors and runs all four pairing combinations. A design that keys the operand choice on the wrong half, for example picking the first operand by row, then corrupts exactly the off-diagonal quadrants.

The all-0x8000 case catches a product formed unsigned or truncated to 16 bits. The 0x80000000 tile case catches saturating or sign-extension mistakes in the subtract.

A second `start` during a busy update, with a different `tile_in`, exposes a design that re-captures its snapshot. Checking `tile_out` on every cycle exposes one that exposes partial quadrants early.

// File: rtl/qtile_pkg.sv
package qtile_pkg;

    localparam int ELEM_W = 32;
    localparam int LANE_W = 16;
    localparam int NQUAD  = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic row_hi;
        logic col_hi;
    } quad_t;

    // quadrant q: row half q/2, column half q mod 2
    function automatic quad_t quad_of(input logic [1:0] q);
        quad_t r;
        r.row_hi = q[1];
        r.col_hi = q[0];
        return r;
    endfunction

    // acc - (a0*b0 + a1*b1), signed lanes, modulo 2^32
    function automatic logic [ELEM_W-1:0] dot2_sub(
        input logic [ELEM_W-1:0] acc,
        input logic [LANE_W-1:0] a0,
        input logic [LANE_W-1:0] a1,
        input logic [LANE_W-1:0] b0,
        input logic [LANE_W-1:0] b1
    );
        logic signed [ELEM_W-1:0] p0;
        logic signed [ELEM_W-1:0] p1;
        p0 = $signed(a0) * $signed(b0);
        p1 = $signed(a1) * $signed(b1);
        return acc - ELEM_W'(p0) - ELEM_W'(p1);
    endfunction

endpackage

// File: rtl/qtile_seq.sv
module qtile_seq
    import qtile_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       busy,
    output logic       load,
    output logic       last,
    output logic [1:0] quad,
    output logic       done
);

    phase_e     phase;
    logic [1:0] q_cnt;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            q_cnt  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_RUN;
                        q_cnt <= '0;
                    end
                end
                PH_RUN: begin
                    q_cnt <= q_cnt + 2'd1;
                    if (q_cnt == 2'(NQUAD - 1)) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase == PH_RUN);
    assign load = (phase == PH_IDLE) && start;
    assign last = busy && (q_cnt == 2'(NQUAD - 1));
    assign quad = q_cnt;
    assign done = done_q;

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a run only begins from an accepted start
    a_r2_run_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9: quadrants advance in order while busy, never restart
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (quad == $past(quad) + 2'd1));

endmodule

// File: rtl/qtile_opsel.sv
module qtile_opsel
    import qtile_pkg::*;
#(
    parameter int VL = 128
) (
    input  logic          pair_a,
    input  logic          pair_b,
    input  quad_t         qd,
    input  logic [VL-1:0] a_lo,
    input  logic [VL-1:0] a_hi,
    input  logic [VL-1:0] b_lo,
    input  logic [VL-1:0] b_hi,
    output logic [VL-1:0] op_a,
    output logic [VL-1:0] op_b
);

    // first operand follows the column half, second follows the row half
    always_comb begin
        op_a = (pair_a && qd.col_hi) ? a_hi : a_lo;
        op_b = (pair_b && qd.row_hi) ? b_hi : b_lo;
    end

endmodule

// File: rtl/qtile_quarter.sv
module qtile_quarter
    import qtile_pkg::*;
#(
    parameter int DIM = 2
) (
    input  quad_t                             qd,
    input  logic [DIM*64-1:0]                 op_a,
    input  logic [DIM*64-1:0]                 op_b,
    input  logic [4*DIM*DIM*ELEM_W-1:0]       work,
    output logic [4*DIM*DIM*ELEM_W-1:0]       next_work
);

    localparam int SIDE = 2 * DIM;
    localparam int IW   = $clog2(SIDE) + 1;
    localparam int QN   = DIM * DIM;

    logic [QN*ELEM_W-1:0] res;

    for (genvar rr = 0; rr < DIM; rr++) begin : g_row
        for (genvar cc = 0; cc < DIM; cc++) begin : g_col
            logic [IW-1:0] row;
            logic [IW-1:0] col;
            assign row = qd.row_hi ? IW'(DIM + rr) : IW'(rr);
            assign col = qd.col_hi ? IW'(DIM + cc) : IW'(cc);
            assign res[(rr*DIM+cc)*ELEM_W +: ELEM_W] = dot2_sub(
                work[(int'(row)*SIDE + int'(col))*ELEM_W +: ELEM_W],
                op_a[(2*int'(row))*LANE_W     +: LANE_W],
                op_a[(2*int'(row)+1)*LANE_W   +: LANE_W],
                op_b[(2*int'(col))*LANE_W     +: LANE_W],
                op_b[(2*int'(col)+1)*LANE_W   +: LANE_W]);
        end
    end

    always_comb begin
        next_work = work;
        for (int rr = 0; rr < DIM; rr++) begin
            for (int cc = 0; cc < DIM; cc++) begin
                next_work[(((qd.row_hi ? DIM : 0) + rr)*SIDE
                           + (qd.col_hi ? DIM : 0) + cc)*ELEM_W +: ELEM_W]
                    = res[(rr*DIM+cc)*ELEM_W +: ELEM_W];
            end
        end
    end

endmodule

// File: rtl/qtile_dotsub.sv
module qtile_dotsub
    import qtile_pkg::*;
#(
    parameter int VL = 128,
    localparam int DIM = VL / 64,
    localparam int TW  = 4 * DIM * DIM * ELEM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          pair_a,
    input  logic          pair_b,
    input  logic [VL-1:0] a_lo,
    input  logic [VL-1:0] a_hi,
    input  logic [VL-1:0] b_lo,
    input  logic [VL-1:0] b_hi,
    input  logic [TW-1:0] tile_in,
    output logic          busy,
    output logic          done,
    output logic [TW-1:0] tile_out
);

    logic          load;
    logic          last;
    logic [1:0]    quad;
    quad_t         qd;
    logic [VL-1:0] op_a;
    logic [VL-1:0] op_b;
    logic [TW-1:0] work;
    logic [TW-1:0] next_work;
    logic [TW-1:0] tile_q;

    qtile_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .load (load),
        .last (last),
        .quad (quad),
        .done (done)
    );

    assign qd = quad_of(quad);

    qtile_opsel #(.VL(VL)) u_opsel (
        .pair_a(pair_a),
        .pair_b(pair_b),
        .qd    (qd),
        .a_lo  (a_lo),
        .a_hi  (a_hi),
        .b_lo  (b_lo),
        .b_hi  (b_hi),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    qtile_quarter #(.DIM(DIM)) u_quarter (
        .qd       (qd),
        .op_a     (op_a),
        .op_b     (op_b),
        .work     (work),
        .next_work(next_work)
    );

    // snapshot on start; each quadrant is rewritten once, so old values stay intact
    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            tile_q <= '0;
        end else if (load) begin
            work <= tile_in;
        end else if (busy) begin
            work <= next_work;
            if (last) tile_q <= next_work;
        end
    end

    assign tile_out = tile_q;

    // R8: the visible tile only moves on completion
    a_r8_tile_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(tile_out));

    // R2: completion always ends a busy period
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

endmodule

// File: tb/qtile_dotsub_tb_top.sv
module qtile_dotsub_tb_top;

    localparam int VL   = 128;
    localparam int DIM  = VL / 64;
    localparam int SIDE = 2 * DIM;
    localparam int TW   = SIDE * SIDE * 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          pair_a, pair_b;
    logic [VL-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [TW-1:0] tile_in;
    logic          busy, done;
    logic [TW-1:0] tile_out;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic [TW-1:0] exp_tile;

    always #2 clk = ~clk;

    qtile_dotsub #(.VL(VL)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .pair_a(pair_a), .pair_b(pair_b),
        .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .tile_in(tile_in),
        .busy(busy), .done(done), .tile_out(tile_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [TW-1:0] model(
        input logic [VL-1:0] al, input logic [VL-1:0] ah,
        input logic [VL-1:0] bl, input logic [VL-1:0] bh,
        input logic pa, input logic pb, input logic [TW-1:0] t);
        logic [TW-1:0] o;
        o = t;
        for (int r = 0; r < SIDE; r++) begin
            for (int c = 0; c < SIDE; c++) begin
                logic [VL-1:0] va, vb;
                longint s, acc;
                va = (pa && c >= DIM) ? ah : al;
                vb = (pb && r >= DIM) ? bh : bl;
                s = 0;
                for (int k = 0; k < 2; k++)
                    s += longint'($signed(va[(2*r+k)*16 +: 16]))
                       * longint'($signed(vb[(2*c+k)*16 +: 16]));
                acc = longint'(t[(r*SIDE+c)*32 +: 32]) - s;
                o[(r*SIDE+c)*32 +: 32] = acc[31:0];
            end
        end
        return o;
    endfunction

    function automatic logic [VL-1:0] rvec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [TW-1:0] rtile();
        logic [TW-1:0] v;
        for (int i = 0; i < TW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // one update, checked on every negedge from accept through one cycle past done
    task automatic run_op(input logic [VL-1:0] al, input logic [VL-1:0] ah,
                          input logic [VL-1:0] bl, input logic [VL-1:0] bh,
                          input logic pa, input logic pb, input logic [TW-1:0] t,
                          input bit poke, input string req);
        logic [TW-1:0] prev, nxt;
        prev = exp_tile;
        nxt  = model(al, ah, bl, bh, pa, pb, t);
        @(negedge clk);
        a_lo = al; a_hi = ah; b_lo = bl; b_hi = bh;
        pair_a = pa; pair_b = pb; tile_in = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            if (i > 1) @(negedge clk);
            if (poke && i == 2) begin
                start = 1'b1; tile_in = ~t;   // R9: ignored while busy
            end else begin
                start = 1'b0;
            end
            chk(done == (i == 5), (poke ? "R9" : "R2"), "done",
                TW'(done), TW'(i == 5));
            chk(busy == (i <= 4), "R2", "busy", TW'(busy), TW'(i <= 4));
            if (i < 5)
                chk(tile_out == prev, "R8", "tile held", tile_out, prev);
            else
                chk(tile_out == nxt, req, "tile result", tile_out, nxt);
        end
        exp_tile = nxt;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] v0, v1, v2, v3;
        logic [TW-1:0] t0;
        void'($urandom(7));
        rst = 1'b1; start = 1'b0; pair_a = 0; pair_b = 0;
        a_lo = '0; a_hi = '0; b_lo = '0; b_hi = '0; tile_in = '0;
        exp_tile = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", "flags", TW'({busy, done}), '0);
        chk(tile_out == '0, "R1", "tile", tile_out, '0);

        // R3: single vectors on both sides, random data
        v0 = rvec(); v1 = rvec(); v2 = rvec(); v3 = rvec();
        run_op(v0, v1, v2, v3, 1'b0, 1'b0, rtile(), 1'b0, "R3");
        // R4: paired first operand
        v0 = rvec(); v1 = rvec(); v2 = rvec(); v3 = rvec();
        run_op(v0, v1, v2, v3, 1'b1, 1'b0, rtile(), 1'b0, "R4");
        // R5: paired second operand
        v0 = rvec(); v1 = rvec(); v2 = rvec(); v3 = rvec();
        run_op(v0, v1, v2, v3, 1'b0, 1'b1, rtile(), 1'b0, "R5");
        // R4 and R5 together, with a start pulse during busy (R9)
        v0 = rvec(); v1 = rvec(); v2 = rvec(); v3 = rvec();
        run_op(v0, v1, v2, v3, 1'b1, 1'b1, rtile(), 1'b1, "R9");

        // R7: extreme lanes, zero tile -> every element 0x80000000
        v0 = {(VL/16){16'h8000}};
        run_op(v0, v0, v0, v0, 1'b1, 1'b1, '0, 1'b0, "R7");
        chk(tile_out[31:0] == 32'h8000_0000, "R7", "elem0 direct",
            TW'(tile_out[31:0]), TW'(32'h8000_0000));
        chk(tile_out[TW-1 -: 32] == 32'h8000_0000, "R7", "last elem direct",
            TW'(tile_out[TW-1 -: 32]), TW'(32'h8000_0000));

        // R6: wraparound 0x80000000 - (1*1 + 1*1) = 0x7FFFFFFE
        v0 = {(VL/16){16'h0001}};
        t0 = {(TW/32){32'h8000_0000}};
        run_op(v0, v0, v0, v0, 1'b0, 1'b0, t0, 1'b0, "R6");
        chk(tile_out == {(TW/32){32'h7FFF_FFFE}}, "R6", "wrap direct",
            tile_out, {(TW/32){32'h7FFF_FFFE}});

        // back-to-back random with mixed pairing
        for (int n = 0; n < 4; n++) begin
            v0 = rvec(); v1 = rvec(); v2 = rvec(); v3 = rvec();
            run_op(v0, v1, v2, v3, n[0], n[1], rtile(), 1'b0, "R3");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule